// File: doc/BRIEF.md
# Serial Audio Link Frame Transmitter

This block is the controller end of an AC97-style serial audio link. It runs on the bit clock that the codec supplies and produces the two lines the controller drives: a frame marker (SYNC) and a serial data line. Each frame is 256 bit periods long. It holds a 16-bit tag that says which slots carry data, followed by twelve 20-bit slots, and every field goes out most significant bit first. All outputs change on rising bit-clock edges, so the codec can capture them on the falling edges.

Stereo PCM samples arrive on a parallel ready/valid port, and an optional command (register address plus data word) arrives on a second ready/valid port. Each port has a one-entry holding register. Whatever is held is moved into the frame at the frame boundary, so a slot never mixes two transfers. A one-cycle request strobe marks each frame boundary so that upstream logic can pace its sample production. Samples are narrower than the slot and are placed left-justified, with the spare low-order bits driven as zeros.

After a synchronous reset the transmitter stays silent for one full frame before it raises SYNC again. This keeps the spacing between any two SYNC rising edges at 256 bit periods or more, so the codec never receives a truncated frame that it would throw away.

Top module: `aclink_frame_tx`

## Requirements
- R1: Outside reset, consecutive rising edges of `syncOut` are exactly 256 bit-clock periods apart.
- R2: `syncOut` rises one bit period before the first tag bit appears on `sdataOut`. It stays high for 16 periods (through tag bit 1) and is low for the other 240.
- R3: Each frame is sent as a 16-bit tag followed by slots 1 to 12 of 20 bits each. Every field is sent MSB first, and `sdataOut` changes only on rising bit-clock edges.
- R4: The tag is laid out as follows. Bit 15 (sent first) is set when any slot in the frame is valid. Bits 14, 13, 12 and 11 flag slots 1, 2, 3 and 4 as valid. Bits 10 to 0 are zero.
- R5: When a command is held, slot 1 carries `cmdAddr` and slot 2 carries `cmdData`, both 20 bits. Otherwise both slots are zero and their tag bits are clear.
- R6: When a sample pair is held, slot 3 carries `pcmLeft` and slot 4 carries `pcmRight`. Each sample is placed in bits 19 to 2 of its slot, and bits 1 and 0 are zero. Slots 5 to 12 are always zero.
- R7: Each port holds at most one transfer. Its ready output is low while a transfer is held, and any value offered while ready is low is ignored. The held transfer goes into the frame whose SYNC rising edge comes next and is then released. A frame with nothing held carries all zeros.
- R8: `sampleReq` is high for exactly one cycle per frame: the cycle in which `syncOut` has just risen.
- R9: While `rst` is high, `syncOut`, `sdataOut`, `sampleReq`, `pcmReady` and `cmdReady` are low and both holding registers are emptied. After `rst` falls, both lines stay low until `syncOut` rises on the 256th rising edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Bit clock from the codec |
| rst | input | 1 | Synchronous reset, active high |
| pcmLeft | input | SAMPLE_W | Left sample |
| pcmRight | input | SAMPLE_W | Right sample |
| pcmValid | input | 1 | Sample pair offered |
| pcmReady | output | 1 | Sample holding register empty |
| cmdAddr | input | 20 | Command address word (slot 1) |
| cmdData | input | 20 | Command data word (slot 2) |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Command holding register empty |
| syncOut | output | 1 | Frame marker line |
| sdataOut | output | 1 | Serial data line |
| sampleReq | output | 1 | One-cycle strobe at each frame boundary |

## Verification
The bench builds the block with the default 18-bit sample width, which leaves two pad bits in each audio slot. Full-scale and alternating sample patterns therefore reach the zero-fill positions next to a set sample LSB. The slot geometry is fixed by the link, so each captured frame can be compared bit by bit with a frame the bench assembles from its own tag and slot layout. The same default also fixes the 256-cycle silence after reset that the bench counts edge by edge, both from power-up and from a reset asserted in the middle of a frame.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int TAG_BITS   = 16;
  localparam int SLOT_BITS  = 20;
  localparam int DATA_SLOTS = 12;
  localparam int FRAME_BITS = TAG_BITS + DATA_SLOTS * SLOT_BITS;
  localparam int SEL_W      = $clog2(DATA_SLOTS + 1);
  localparam int BIT_W      = $clog2(SLOT_BITS);

  // strobes from the sequencer to the datapath, valid for the coming edge
  typedef struct packed {
    logic             slotStart;  // coming edge launches the MSB of a field
    logic [SEL_W-1:0] slotSel;    // 0 = tag, 1..DATA_SLOTS = data slot
    logic             frameLoad;  // coming edge is the frame boundary
    logic             outEn;      // data line enabled
    logic             syncNext;   // value SYNC takes at the coming edge
  } txStrobe_t;
endpackage

// File: rtl/aclink_tx_ctrl.sv
module aclink_tx_ctrl
  import aclink_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  output txStrobe_t strb
);
  localparam logic [SEL_W-1:0] LAST_SLOT = SEL_W'(DATA_SLOTS);
  localparam logic [BIT_W-1:0] TAG_TOP   = BIT_W'(TAG_BITS - 1);
  localparam logic [BIT_W-1:0] SLOT_TOP  = BIT_W'(SLOT_BITS - 1);

  logic [SEL_W-1:0] slotIdx;   // field holding the bit launched next
  logic [BIT_W-1:0] bitLeft;   // bits of that field still to follow it
  logic             armed;     // a full silent frame has passed since reset
  logic             wrap;

  assign wrap = (slotIdx == LAST_SLOT) && (bitLeft == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      slotIdx <= '0;
      bitLeft <= TAG_TOP;
      armed   <= 1'b0;
    end else begin
      if (bitLeft == '0) begin
        slotIdx <= wrap ? '0 : slotIdx + SEL_W'(1);
        bitLeft <= wrap ? TAG_TOP : SLOT_TOP;
      end else begin
        bitLeft <= bitLeft - BIT_W'(1);
      end
      armed <= armed | wrap;
    end
  end

  always_comb begin
    strb.slotStart = (slotIdx == '0) ? (bitLeft == TAG_TOP) : (bitLeft == SLOT_TOP);
    strb.slotSel   = slotIdx;
    strb.frameLoad = wrap;
    strb.outEn     = armed;
    // SYNC covers the last bit of a frame and tag bits 15..1 of the next
    strb.syncNext  = wrap || (armed && (slotIdx == '0) && (bitLeft != '0));
  end
endmodule

// File: rtl/aclink_tx_dpath.sv
module aclink_tx_dpath
  import aclink_pkg::*;
#(
  parameter int SAMPLE_W = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  txStrobe_t            strb,
  input  logic [SAMPLE_W-1:0]  pcmLeft,
  input  logic [SAMPLE_W-1:0]  pcmRight,
  input  logic                 pcmValid,
  output logic                 pcmReady,
  input  logic [SLOT_BITS-1:0] cmdAddr,
  input  logic [SLOT_BITS-1:0] cmdData,
  input  logic                 cmdValid,
  output logic                 cmdReady,
  output logic                 syncOut,
  output logic                 sdataOut,
  output logic                 sampleReq
);
  localparam int PAD_W = SLOT_BITS - SAMPLE_W;

  logic [SAMPLE_W-1:0]  pendLeft, pendRight, frLeft, frRight;
  logic [SLOT_BITS-1:0] pendAddr, pendData, frAddr, frData;
  logic                 pcmHeld, cmdHeld, frPcmOn, frCmdOn;
  logic                 pcmTake, cmdTake;
  logic [SLOT_BITS-1:0] leftJ, rightJ, word, shiftReg;
  logic [DATA_SLOTS-1:0] slotOn;
  logic [TAG_BITS-1:0]  tagBits;

  assign pcmReady = ~pcmHeld & ~rst;
  assign cmdReady = ~cmdHeld & ~rst;
  assign pcmTake  = pcmValid & pcmReady;
  assign cmdTake  = cmdValid & cmdReady;

  // holding registers and frame registers
  always_ff @(posedge clk) begin
    if (rst) begin
      pcmHeld <= 1'b0;
      cmdHeld <= 1'b0;
      frPcmOn <= 1'b0;
      frCmdOn <= 1'b0;
      pendLeft <= '0; pendRight <= '0; frLeft <= '0; frRight <= '0;
      pendAddr <= '0; pendData  <= '0; frAddr <= '0; frData  <= '0;
    end else begin
      if (strb.frameLoad) begin
        frLeft  <= pendLeft;
        frRight <= pendRight;
        frAddr  <= pendAddr;
        frData  <= pendData;
        frPcmOn <= pcmHeld;
        frCmdOn <= cmdHeld;
        pcmHeld <= 1'b0;
        cmdHeld <= 1'b0;
      end
      if (pcmTake) begin
        pendLeft  <= pcmLeft;
        pendRight <= pcmRight;
        pcmHeld   <= 1'b1;
      end
      if (cmdTake) begin
        pendAddr <= cmdAddr;
        pendData <= cmdData;
        cmdHeld  <= 1'b1;
      end
    end
  end

  // left-justified sample placement; the pad width picks the variant
  generate
    if (PAD_W == 0) begin : g_nopad
      assign leftJ  = frLeft;
      assign rightJ = frRight;
    end else begin : g_pad
      assign leftJ  = {frLeft,  PAD_W'(0)};
      assign rightJ = {frRight, PAD_W'(0)};
    end
  endgenerate

  always_comb begin
    slotOn    = '0;
    slotOn[0] = frCmdOn;
    slotOn[1] = frCmdOn;
    slotOn[2] = frPcmOn;
    slotOn[3] = frPcmOn;
    tagBits   = '0;
    tagBits[TAG_BITS-1] = |slotOn;
    for (int i = 0; i < DATA_SLOTS; i++) tagBits[TAG_BITS-2-i] = slotOn[i];
  end

  always_comb begin
    case (strb.slotSel)
      SEL_W'(0): word = {tagBits, (SLOT_BITS - TAG_BITS)'(0)};
      SEL_W'(1): word = frCmdOn ? frAddr : '0;
      SEL_W'(2): word = frCmdOn ? frData : '0;
      SEL_W'(3): word = frPcmOn ? leftJ  : '0;
      SEL_W'(4): word = frPcmOn ? rightJ : '0;
      default:   word = '0;
    endcase
  end

  // serializer: all line changes on the rising edge
  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg  <= '0;
      sdataOut  <= 1'b0;
      syncOut   <= 1'b0;
      sampleReq <= 1'b0;
    end else begin
      if (strb.slotStart) begin
        sdataOut <= strb.outEn & word[SLOT_BITS-1];
        shiftReg <= word << 1;
      end else begin
        sdataOut <= strb.outEn & shiftReg[SLOT_BITS-1];
        shiftReg <= shiftReg << 1;
      end
      syncOut   <= strb.syncNext;
      sampleReq <= strb.frameLoad;
    end
  end
endmodule

// File: rtl/aclink_frame_tx.sv
module aclink_frame_tx
  import aclink_pkg::*;
#(
  parameter int SAMPLE_W = 18
) (
  input  logic                 bitClk,
  input  logic                 rst,
  input  logic [SAMPLE_W-1:0]  pcmLeft,
  input  logic [SAMPLE_W-1:0]  pcmRight,
  input  logic                 pcmValid,
  output logic                 pcmReady,
  input  logic [SLOT_BITS-1:0] cmdAddr,
  input  logic [SLOT_BITS-1:0] cmdData,
  input  logic                 cmdValid,
  output logic                 cmdReady,
  output logic                 syncOut,
  output logic                 sdataOut,
  output logic                 sampleReq
);
  txStrobe_t strb;

  aclink_tx_ctrl u_ctrl (
    .clk  (bitClk),
    .rst  (rst),
    .strb (strb)
  );

  aclink_tx_dpath #(.SAMPLE_W(SAMPLE_W)) u_dpath (
    .clk       (bitClk),
    .rst       (rst),
    .strb      (strb),
    .pcmLeft   (pcmLeft),
    .pcmRight  (pcmRight),
    .pcmValid  (pcmValid),
    .pcmReady  (pcmReady),
    .cmdAddr   (cmdAddr),
    .cmdData   (cmdData),
    .cmdValid  (cmdValid),
    .cmdReady  (cmdReady),
    .syncOut   (syncOut),
    .sdataOut  (sdataOut),
    .sampleReq (sampleReq)
  );
endmodule

// File: rtl/aclink_frame_tx_chk.sv
module aclink_frame_tx_chk
  import aclink_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic syncOut,
  input logic sdataOut,
  input logic sampleReq,
  input logic pcmValid,
  input logic pcmReady
);
  logic       syncQ, seen, rose;
  logic [9:0] cycQ;   // 1 while data position 0 is on the line

  assign rose = syncOut & ~syncQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ <= 1'b0;
      seen  <= 1'b0;
      cycQ  <= '0;
    end else begin
      syncQ <= syncOut;
      if (rose) begin
        seen <= 1'b1;
        cycQ <= 10'd1;
      end else if (cycQ != '1) begin
        cycQ <= cycQ + 10'd1;
      end
    end
  end

  // R1
  frame_period_chk: assert property (@(posedge clk) disable iff (rst)
    (rose && seen) |-> (cycQ == 10'(FRAME_BITS)));

  // R2
  sync_high_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && !rose && cycQ >= 10'd1 && cycQ <= 10'(TAG_BITS - 1)) |-> syncOut);

  // R2
  sync_low_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && cycQ >= 10'(TAG_BITS) && cycQ < 10'(FRAME_BITS)) |-> !syncOut);

  // R4 tag bits 10..0 sit at positions 5..15
  tag_tail_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && cycQ >= 10'd6 && cycQ <= 10'd16) |-> !sdataOut);

  // R6 pad bits of slots 3 and 4
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && (cycQ == 10'd75 || cycQ == 10'd76 || cycQ == 10'd95 || cycQ == 10'd96))
      |-> !sdataOut);

  // R6 slots 5..12
  tail_slots_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && cycQ >= 10'd97 && cycQ <= 10'(FRAME_BITS)) |-> !sdataOut);

  // R7
  hold_full_chk: assert property (@(posedge clk) disable iff (rst)
    (pcmValid && pcmReady) |=> !pcmReady);

  // R8
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sampleReq |=> !sampleReq);

  // R8
  req_align_chk: assert property (@(posedge clk) disable iff (rst)
    sampleReq |-> rose);

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!syncOut && !sdataOut && !sampleReq));
endmodule

bind aclink_frame_tx aclink_frame_tx_chk u_chk (
  .clk       (bitClk),
  .rst       (rst),
  .syncOut   (syncOut),
  .sdataOut  (sdataOut),
  .sampleReq (sampleReq),
  .pcmValid  (pcmValid),
  .pcmReady  (pcmReady)
);

// File: tb/aclink_frame_tx_tb.sv
module aclink_frame_tx_tb;
  import aclink_pkg::*;
  localparam int SW = 18;

  logic bitClk = 1'b0;
  logic rst = 1'b1;
  logic [SW-1:0] pcmLeft = '0, pcmRight = '0;
  logic pcmValid = 1'b0, cmdValid = 1'b0;
  logic [SLOT_BITS-1:0] cmdAddr = '0, cmdData = '0;
  logic pcmReady, cmdReady, syncOut, sdataOut, sampleReq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [FRAME_BITS-1:0] capData, capSync;
  int reqSeen;
  bit reqAtRise;

  always #5 bitClk = ~bitClk;

  aclink_frame_tx #(.SAMPLE_W(SW)) u_dut (
    .bitClk(bitClk), .rst(rst),
    .pcmLeft(pcmLeft), .pcmRight(pcmRight), .pcmValid(pcmValid), .pcmReady(pcmReady),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .syncOut(syncOut), .sdataOut(sdataOut), .sampleReq(sampleReq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [FRAME_BITS-1:0] act, input logic [FRAME_BITS-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [FRAME_BITS-1:0] expFrame(
      bit cOn, logic [SLOT_BITS-1:0] a, logic [SLOT_BITS-1:0] d,
      bit pOn, logic [SW-1:0] l, logic [SW-1:0] r);
    logic [TAG_BITS-1:0]  tag;
    logic [SLOT_BITS-1:0] s1, s2, s3, s4;
    tag = '0;
    tag[15] = cOn | pOn;
    tag[14] = cOn;
    tag[13] = cOn;
    tag[12] = pOn;
    tag[11] = pOn;
    s1 = cOn ? a : '0;
    s2 = cOn ? d : '0;
    s3 = pOn ? {l, 2'b00} : '0;
    s4 = pOn ? {r, 2'b00} : '0;
    return {tag, s1, s2, s3, s4, {(8 * SLOT_BITS){1'b0}}};
  endfunction

  function automatic logic [FRAME_BITS-1:0] expSync();
    logic [FRAME_BITS-1:0] v;
    v = '0;
    for (int i = 0; i < FRAME_BITS; i++)
      if (i < TAG_BITS - 1 || i == FRAME_BITS - 1) v[FRAME_BITS-1-i] = 1'b1;
    return v;
  endfunction

  // leaves the bench at the negedge right after SYNC has risen
  task automatic waitRise();
    logic p;
    p = 1'b1;
    while (!(syncOut && !p)) begin
      p = syncOut;
      @(negedge bitClk);
    end
  endtask

  task automatic capture(input bit skipToNext);
    if (skipToNext) waitRise();
    reqAtRise = sampleReq;
    reqSeen = sampleReq ? 1 : 0;
    for (int i = 0; i < FRAME_BITS; i++) begin
      @(negedge bitClk);
      capData[FRAME_BITS-1-i] = sdataOut;
      capSync[FRAME_BITS-1-i] = syncOut;
      if (i != FRAME_BITS - 1 && sampleReq) reqSeen++;
    end
  endtask

  task automatic offerPcm(input logic [SW-1:0] l, input logic [SW-1:0] r);
    pcmLeft = l; pcmRight = r; pcmValid = 1'b1;
    @(negedge bitClk);
    pcmValid = 1'b0;
  endtask

  task automatic offerCmd(input logic [SLOT_BITS-1:0] a, input logic [SLOT_BITS-1:0] d);
    cmdAddr = a; cmdData = d; cmdValid = 1'b1;
    @(negedge bitClk);
    cmdValid = 1'b0;
  endtask

  task automatic test_reset();
    int n;
    bit dataSeen;
    repeat (3) @(negedge bitClk);
    check(!syncOut && !sdataOut && !sampleReq, "R9", "lines low in reset",
          {syncOut, sdataOut, sampleReq}, '0);
    check(!pcmReady && !cmdReady, "R9", "ready low in reset", {pcmReady, cmdReady}, '0);
    rst = 1'b0;
    n = 0;
    dataSeen = 1'b0;
    do begin
      @(negedge bitClk);
      n++;
      if (sdataOut) dataSeen = 1'b1;
    end while (!syncOut && n < 400);
    check(n == FRAME_BITS, "R9", "edges until first SYNC", n, FRAME_BITS);
    check(!dataSeen, "R9", "data quiet before first frame", dataSeen, 0);
    check(pcmReady && cmdReady, "R7", "ready after reset", {pcmReady, cmdReady}, 2'b11);
  endtask

  task automatic test_idle();
    capture(1'b0);
    check(capData == '0, "R7", "empty frame", capData, '0);
    check(capSync == expSync(), "R2", "SYNC pattern", capSync, expSync());
    check(capSync[0] && !capSync[1], "R1", "next rise after 256", capSync[1:0], 2'b01);
    check(reqAtRise && reqSeen == 1, "R8", "one request at rise", reqSeen, 1);
  endtask

  task automatic test_pcm(input logic [SW-1:0] l, input logic [SW-1:0] r, input string req);
    waitRise();
    offerPcm(l, r);
    capture(1'b1);
    check(capData == expFrame(1'b0, '0, '0, 1'b1, l, r), req, "audio frame",
          capData, expFrame(1'b0, '0, '0, 1'b1, l, r));
  endtask

  task automatic test_cmd();
    waitRise();
    offerCmd(20'hA5C3E, 20'h0F1E2);
    capture(1'b1);
    check(capData == expFrame(1'b1, 20'hA5C3E, 20'h0F1E2, 1'b0, '0, '0), "R5",
          "command frame", capData, expFrame(1'b1, 20'hA5C3E, 20'h0F1E2, 1'b0, '0, '0));
  endtask

  task automatic test_both();
    waitRise();
    pcmLeft = 18'h15555; pcmRight = 18'h2AAAA; pcmValid = 1'b1;
    cmdAddr = 20'h80000; cmdData = 20'h00001; cmdValid = 1'b1;
    @(negedge bitClk);
    pcmValid = 1'b0; cmdValid = 1'b0;
    capture(1'b1);
    check(capData == expFrame(1'b1, 20'h80000, 20'h00001, 1'b1, 18'h15555, 18'h2AAAA),
          "R4", "combined frame MSB first (R3)", capData,
          expFrame(1'b1, 20'h80000, 20'h00001, 1'b1, 18'h15555, 18'h2AAAA));
    check(reqSeen == 1, "R8", "request count", reqSeen, 1);
  endtask

  task automatic test_hold();
    bit readySeen;
    waitRise();
    offerPcm(18'h12345, 18'h06789);
    check(!pcmReady, "R7", "ready low while held", pcmReady, 0);
    readySeen = 1'b0;
    pcmLeft = 18'h3FFFF; pcmRight = 18'h3FFFF; pcmValid = 1'b1;
    repeat (10) begin
      @(negedge bitClk);
      if (pcmReady) readySeen = 1'b1;
    end
    pcmValid = 1'b0;
    check(!readySeen, "R7", "ready stays low", readySeen, 0);
    capture(1'b1);
    check(capData == expFrame(1'b0, '0, '0, 1'b1, 18'h12345, 18'h06789), "R7",
          "blocked offer ignored", capData, expFrame(1'b0, '0, '0, 1'b1, 18'h12345, 18'h06789));
    capture(1'b0);
    check(capData == '0, "R7", "released after one frame", capData, '0);
  endtask

  task automatic test_midreset();
    int n;
    waitRise();
    offerPcm(18'h0F0F0, 18'h30303);
    repeat (100) @(negedge bitClk);
    rst = 1'b1;
    repeat (3) @(negedge bitClk);
    check(!syncOut && !sdataOut, "R9", "mid-frame reset quiet", {syncOut, sdataOut}, '0);
    rst = 1'b0;
    n = 0;
    do begin
      @(negedge bitClk);
      n++;
    end while (!syncOut && n < 400);
    check(n == FRAME_BITS, "R9", "no early SYNC after reset", n, FRAME_BITS);
    capture(1'b0);
    check(capData == '0, "R9", "held sample dropped by reset", capData, '0);
  endtask

  initial begin
    test_reset();
    test_idle();
    test_pcm(18'h3FFFF, 18'h20001, "R6");
    test_pcm(18'h2468A, 18'h13579, "R6");
    test_cmd();
    test_both();
    test_hold();
    test_midreset();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge bitClk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule